// File: doc/BRIEF.md
# Two-Way One-Hot Traffic Light Controller

This block sequences the lamps of a crossing with two opposing approaches, named left and right. A ten-position state register holds a single set bit that walks one place each time the tick input is high on a clock edge. After the last position it returns to the first, much like a decade counter with decoded outputs. The tick is expected to arrive about once per second from logic outside the block.

Each of the six lamp outputs is a plain OR of state positions. The left side shows green for four positions and then yellow for one position. The right side then repeats the same pattern over the other five positions. The red lamp of a side stays lit through both the green and the yellow phase of the opposite side. The raw state vector is also brought out. If the register ever holds a pattern that is not one-hot, the next clock edge puts it back at the first position.

Top module: `twoway_signal`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the state output phase to 10'b0000000001 (position 0), whatever the value of tick. While it is there, left green and right red are the only lamps lit.
- R2: At a clock edge with rst low and tick high, the set bit moves from position p to position p+1. From position 9 it moves to position 0. Position p is phase bit p.
- R3: At a clock edge with rst low and tick low, phase keeps its value and so do all the lamps.
- R4: left_green is high exactly when the state is in positions 0, 1, 2 or 3.
- R5: left_yellow is high exactly when the state is in position 4.
- R6: left_red is high exactly when the state is in positions 5 to 9.
- R7: right_green is high exactly in positions 5 to 8, and right_yellow exactly in position 9. right_red is high exactly in positions 0 to 4.
- R8: On each side exactly one of the three lamps is lit in every cycle, and left_green and right_green are never high together.
- R9: After reset, phase always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Step enable, one position per high cycle |
| left_green | output | 1 | Left green lamp |
| left_yellow | output | 1 | Left yellow lamp |
| left_red | output | 1 | Left red lamp |
| right_green | output | 1 | Right green lamp |
| right_yellow | output | 1 | Right yellow lamp |
| right_red | output | 1 | Right red lamp |
| phase | output | 10 | One-hot sequence position |

## Verification
The assertions check the following on every cycle: the one-hot property of phase, single-bit rotation on a tick, holding when there is no tick, one lamp per side with no double green, and the hand-over from yellow to the other side. The exact mapping of positions to lamps and the reset value can only be shown by the bench's reference model. It tracks the position as an integer through continuous ticking, long gaps, irregular tick patterns and resets applied in the middle of the sequence with tick high, and it checks all of these across several wraps from position 9 to position 0.

// File: rtl/twoway_signal.sv
module twoway_signal #(
  parameter int GREEN_LEN = 4,
  localparam int HALF = GREEN_LEN + 1,
  localparam int NPOS = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic            left_green,
  output logic            left_yellow,
  output logic            left_red,
  output logic            right_green,
  output logic            right_yellow,
  output logic            right_red,
  output logic [NPOS-1:0] phase
);

  logic [NPOS-1:0] phase_q;
  logic            legal;

  assign legal = $onehot(phase_q);

  always_ff @(posedge clk) begin
    if (rst || !legal)
      phase_q <= NPOS'(1);
    else if (tick)
      phase_q <= {phase_q[NPOS-2:0], phase_q[NPOS-1]};
  end

  assign phase        = phase_q;
  assign left_green   = |phase_q[GREEN_LEN-1:0];
  assign left_yellow  = phase_q[GREEN_LEN];
  assign left_red     = |phase_q[NPOS-1:HALF];
  assign right_green  = |phase_q[HALF+GREEN_LEN-1:HALF];
  assign right_yellow = phase_q[NPOS-1];
  assign right_red    = |phase_q[HALF-1:0];

endmodule

// File: rtl/twoway_signal_chk.sv
module twoway_signal_chk #(
  parameter int NPOS = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic            left_green,
  input logic            left_yellow,
  input logic            left_red,
  input logic            right_green,
  input logic            right_yellow,
  input logic            right_red,
  input logic [NPOS-1:0] phase
);

  // R9
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase == $past({phase[NPOS-2:0], phase[NPOS-1]}));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase) && $stable({left_green, left_yellow, left_red,
                                         right_green, right_yellow, right_red}));

  // R8
  one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({left_green, left_yellow, left_red}) == 1 &&
    $countones({right_green, right_yellow, right_red}) == 1 &&
    !(left_green && right_green));

  // R6
  left_handover_chk: assert property (@(posedge clk) disable iff (rst)
    left_yellow && tick |=> left_red && right_green);

  // R7
  right_handover_chk: assert property (@(posedge clk) disable iff (rst)
    right_yellow && tick |=> left_green && right_red);

endmodule

bind twoway_signal twoway_signal_chk #(.NPOS(NPOS)) chk_i (
  .clk(clk), .rst(rst), .tick(tick),
  .left_green(left_green), .left_yellow(left_yellow), .left_red(left_red),
  .right_green(right_green), .right_yellow(right_yellow), .right_red(right_red),
  .phase(phase)
);

// File: tb/twoway_signal_tb_top.sv
module twoway_signal_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic lg, ly, lr, rg, ry, rr;
  logic [9:0] phase;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  int seed = 7;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoway_signal dut_i (
    .clk(clk), .rst(rst), .tick(tick),
    .left_green(lg), .left_yellow(ly), .left_red(lr),
    .right_green(rg), .right_yellow(ry), .right_red(rr),
    .phase(phase)
  );

  always @(posedge clk) begin
    if (rst) pos <= 0;
    else if (tick) pos <= (pos + 1) % 10;
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int one;
    one = 1 << pos;
    check("R2/R3 phase", int'(phase), one);
    check("R4 left_green", int'(lg), int'(pos <= 3));
    check("R5 left_yellow", int'(ly), int'(pos == 4));
    check("R6 left_red", int'(lr), int'(pos >= 5));
    check("R7 right_green", int'(rg), int'(pos >= 5 && pos <= 8));
    check("R7 right_yellow", int'(ry), int'(pos == 9));
    check("R7 right_red", int'(rr), int'(pos <= 4));
    check("R8 one lamp per side", int'(lg) + int'(ly) + int'(lr) + 10 * (int'(rg) + int'(ry) + int'(rr)), 11);
    check("R8 no double green", int'(lg && rg), 0);
    check("R9 onehot", $countones(phase), 1);
  endtask

  task automatic step(input logic r, input logic t);
    rst = r;
    tick = t;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R2 watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b1);
    // R1: reset state
    check("R1 reset phase", int'(phase), 1);
    check("R1 reset lamps", int'({lg, ly, lr, rg, ry, rr}), 6'b100001);
    // R2: continuous ticking, three wraps
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1);
    // R3: long hold
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
    // R2/R3: alternate ticks
    for (int i = 0; i < 25; i++) step(1'b0, i[0]);
    // R1: reset mid-sequence with tick high
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check("R1 mid reset phase", int'(phase), 1);
    step(1'b1, 1'b0);
    // irregular tick pattern
    for (int i = 0; i < 400; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step(((seed >> 20) % 50) == 0, ((seed >> 8) % 3) != 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule